// File: doc/BRIEF.md
# Readout Clock-Enable and Integration Window Generator

This block derives the timing of a line sensor's readout from the 60 MHz system clock. A programmable divider makes a one-cycle enable at every half period of the sensor's odd/even readout clock. It also carries the level of that clock, so that a full odd/even period lasts twice the divider value in system cycles. A pixel strobe marks every eighth full period, so the pixel rate is one eighth of the odd/even rate. While acquisition runs, the block repeats a frame: an integration window that lasts a programmed number of odd/even periods, followed by a short gap.

A new divider value is only staged when it is loaded. While the block runs, the staged value takes effect at the end of the current full period, so no period is ever shortened. While the block is stopped, the staged value takes effect on the next cycle. A divider value of zero is rejected. Two mode outputs are also produced. The effective high-speed flag is the speed request unless parallel interface style is selected, which forces normal speed. The gain-select output follows its mode bit.

Top module: `oe_timing_gen`

## Requirements
- R1: While `run_en` is high, `oe_clk_lvl` starts low and toggles every D system cycles, where D is the active divider. `oe_clk_en` is high for exactly the one cycle before each toggle, so the first pulse comes D-1 cycles after `run_en` rises and the first high level comes D cycles after it.
- R2: A `div_load` with `div_value` equal to 0 is ignored, and the previously staged or active divider stays in effect.
- R3: A divider loaded while running is applied only at the end of a full period, which is the toggle from high to low. The half period in progress keeps the old length. A divider loaded while stopped is active before the next run.
- R4: After reset the active divider is DIV_RST (10 by default), and `oe_clk_en`, `oe_clk_lvl`, `pix_stb` and `integ_active` are low while `run_en` is low.
- R5: `pix_stb` is a one-cycle pulse at the end of every PIX_RATIO-th full period (default 8). It coincides with `oe_clk_en` while `oe_clk_lvl` is high, and the first pulse comes 16·D-1 cycles after `run_en` rises.
- R6: `integ_active` rises in the same cycle that `run_en` rises and stays high for N·2·D cycles, where N is `int_time`. A value of N equal to 0 is counted as 1.
- R7: After each integration window, `integ_active` is low for GAP_PERIODS full periods (default 1). Then a new window opens at a period boundary, with `int_time` sampled again.
- R8: When `run_en` is low, `oe_clk_en`, `pix_stb` and `integ_active` are low in that same cycle, and `oe_clk_lvl` is low from the next cycle on.
- R9: `speed_hi` equals `hi_speed` when `par_style` is 0, and is forced to 0 when `par_style` is 1.
- R10: `gain_hi` follows `gain_in` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 60 MHz system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Acquisition enable (sensor-control bit) |
| div_value | input | DIV_W (9) | Divider value to stage |
| div_load | input | 1 | One-cycle strobe that stages `div_value` |
| int_time | input | INT_W (32) | Integration length in odd/even periods |
| par_style | input | 1 | Parallel interface style selected |
| hi_speed | input | 1 | High-speed mode requested |
| gain_in | input | 1 | Gain mode bit |
| oe_clk_en | output | 1 | Half-period enable of the odd/even clock |
| oe_clk_lvl | output | 1 | Level of the odd/even clock |
| pix_stb | output | 1 | Pixel strobe, one cycle per PIX_RATIO periods |
| integ_active | output | 1 | Integration window |
| speed_hi | output | 1 | Effective high-speed flag |
| gain_hi | output | 1 | Gain-select drive |

## Verification
The assertions assume that `run_en`, `div_load` and the mode bits change only between clock edges and are stable at the sampling edge. They also assume that reset is applied before any run. The bench drives every input on the falling edge. It pulses `div_load` for exactly one cycle and holds `run_en` low for several cycles before each new run, so that each run starts from the idle state with the staged divider applied. It samples outputs one time unit after a falling edge and counts cycles from the first sample of each run.

// File: rtl/oe_timing_pkg.sv
package oe_timing_pkg;
   typedef enum logic [1:0] {
      IW_IDLE = 2'd0,
      IW_OPEN = 2'd1,
      IW_GAP  = 2'd2
   } iw_state_t;
endpackage

// File: rtl/oe_half_div.sv
module oe_half_div #(
   parameter int DIV_W   = 9,
   parameter int DIV_RST = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic [DIV_W-1:0] div_value,
   input  logic             div_load,
   output logic             tick,
   output logic             lvl,
   output logic             period_end
);
   localparam logic [DIV_W-1:0] ONE   = DIV_W'(1);
   localparam logic [DIV_W-1:0] RSTV  = DIV_W'(DIV_RST);

   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] div_act_q;
   logic [DIV_W-1:0] div_pend_q;
   logic             pend_vld_q;
   logic             lvl_q;

   assign tick       = run_en && (cnt_q == (div_act_q - ONE));
   assign lvl        = lvl_q;
   assign period_end = tick && lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q      <= '0;
         lvl_q      <= 1'b0;
         div_act_q  <= RSTV;
         div_pend_q <= RSTV;
         pend_vld_q <= 1'b0;
      end else begin
         if (!run_en) begin
            cnt_q <= '0;
            lvl_q <= 1'b0;
            if (pend_vld_q) begin
               div_act_q  <= div_pend_q;
               pend_vld_q <= 1'b0;
            end
         end else if (tick) begin
            cnt_q <= '0;
            lvl_q <= ~lvl_q;
            if (lvl_q && pend_vld_q) begin
               div_act_q  <= div_pend_q;
               pend_vld_q <= 1'b0;
            end
         end else begin
            cnt_q <= cnt_q + ONE;
         end
         if (div_load && (div_value != '0)) begin
            div_pend_q <= div_value;
            pend_vld_q <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/oe_pixel_strobe.sv
module oe_pixel_strobe #(
   parameter int RATIO = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_en,
   input  logic period_end,
   output logic pix_stb
);
   localparam int              PW   = (RATIO > 1) ? $clog2(RATIO) : 1;
   localparam logic [PW-1:0]   LAST = PW'(RATIO - 1);
   localparam logic [PW-1:0]   INC  = PW'(1);

   logic [PW-1:0] pc_q;

   assign pix_stb = period_end && (pc_q == LAST);

   generate
      if ((RATIO & (RATIO - 1)) == 0) begin : g_pow2
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          pc_q <= '0;
            else if (!run_en)    pc_q <= '0;
            else if (period_end) pc_q <= pc_q + INC;
         end
      end else begin : g_mod
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          pc_q <= '0;
            else if (!run_en)    pc_q <= '0;
            else if (period_end) pc_q <= (pc_q == LAST) ? '0 : pc_q + INC;
         end
      end
   endgenerate
endmodule

// File: rtl/oe_integ_window.sv
module oe_integ_window
   import oe_timing_pkg::*;
#(
   parameter int INT_W       = 32,
   parameter int GAP_PERIODS = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic             period_end,
   input  logic [INT_W-1:0] int_time,
   output logic             integ_active
);
   localparam int               GW    = $clog2(GAP_PERIODS + 1);
   localparam logic [GW-1:0]    GLAST = GW'(GAP_PERIODS - 1);
   localparam logic [GW-1:0]    GINC  = GW'(1);
   localparam logic [INT_W-1:0] IONE  = INT_W'(1);

   iw_state_t        state_q;
   logic [INT_W-1:0] ic_q;
   logic [INT_W-1:0] tgt_q;
   logic [GW-1:0]    gc_q;
   logic [INT_W-1:0] tgt_new;

   assign tgt_new      = (int_time == '0) ? IONE : int_time;
   assign integ_active = run_en && (state_q != IW_GAP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= IW_IDLE;
         ic_q    <= '0;
         tgt_q   <= IONE;
         gc_q    <= '0;
      end else if (!run_en) begin
         state_q <= IW_IDLE;
         ic_q    <= '0;
         gc_q    <= '0;
         tgt_q   <= tgt_new;
      end else begin
         unique case (state_q)
            IW_IDLE: begin
               state_q <= IW_OPEN;
               ic_q    <= '0;
               tgt_q   <= tgt_new;
            end
            IW_OPEN: begin
               if (period_end) begin
                  if (ic_q == (tgt_q - IONE)) begin
                     state_q <= IW_GAP;
                     gc_q    <= '0;
                  end else begin
                     ic_q <= ic_q + IONE;
                  end
               end
            end
            IW_GAP: begin
               if (period_end) begin
                  if (gc_q == GLAST) begin
                     state_q <= IW_OPEN;
                     ic_q    <= '0;
                     tgt_q   <= tgt_new;
                  end else begin
                     gc_q <= gc_q + GINC;
                  end
               end
            end
            default: state_q <= IW_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/oe_timing_gen.sv
module oe_timing_gen #(
   parameter int DIV_W       = 9,
   parameter int DIV_RST     = 10,
   parameter int INT_W       = 32,
   parameter int PIX_RATIO   = 8,
   parameter int GAP_PERIODS = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic [DIV_W-1:0] div_value,
   input  logic             div_load,
   input  logic [INT_W-1:0] int_time,
   input  logic             par_style,
   input  logic             hi_speed,
   input  logic             gain_in,
   output logic             oe_clk_en,
   output logic             oe_clk_lvl,
   output logic             pix_stb,
   output logic             integ_active,
   output logic             speed_hi,
   output logic             gain_hi
);
   generate
      if (DIV_W < 1 || DIV_W > 16) begin : g_bad_divw
         $error("oe_timing_gen: DIV_W out of range");
      end
      if (DIV_RST < 1 || DIV_RST >= (1 << DIV_W)) begin : g_bad_divrst
         $error("oe_timing_gen: DIV_RST must be a nonzero DIV_W value");
      end
      if (INT_W < 1) begin : g_bad_intw
         $error("oe_timing_gen: INT_W must be positive");
      end
      if (PIX_RATIO < 2) begin : g_bad_ratio
         $error("oe_timing_gen: PIX_RATIO must be at least 2");
      end
      if (GAP_PERIODS < 1) begin : g_bad_gap
         $error("oe_timing_gen: GAP_PERIODS must be at least 1");
      end
   endgenerate

   logic period_end;

   oe_half_div #(
      .DIV_W   (DIV_W),
      .DIV_RST (DIV_RST)
   ) div_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_en     (run_en),
      .div_value  (div_value),
      .div_load   (div_load),
      .tick       (oe_clk_en),
      .lvl        (oe_clk_lvl),
      .period_end (period_end)
   );

   oe_pixel_strobe #(
      .RATIO (PIX_RATIO)
   ) pix_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_en     (run_en),
      .period_end (period_end),
      .pix_stb    (pix_stb)
   );

   oe_integ_window #(
      .INT_W       (INT_W),
      .GAP_PERIODS (GAP_PERIODS)
   ) win_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .run_en       (run_en),
      .period_end   (period_end),
      .int_time     (int_time),
      .integ_active (integ_active)
   );

   assign speed_hi = hi_speed & ~par_style;
   assign gain_hi  = gain_in;
endmodule

// File: rtl/oe_timing_chk.sv
module oe_timing_chk (
   input logic clk,
   input logic rst_n,
   input logic run_en,
   input logic par_style,
   input logic oe_clk_en,
   input logic oe_clk_lvl,
   input logic pix_stb,
   input logic integ_active,
   input logic speed_hi
);
   // R1
   lvl_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_clk_lvl != $past(oe_clk_lvl)) |-> ($past(oe_clk_en) || !$past(run_en)));

   // R1
   tick_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oe_clk_en |-> run_en);

   // R5
   pix_at_period_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pix_stb |-> (oe_clk_en && oe_clk_lvl));

   // R6
   window_opens_with_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_en) |-> integ_active);

   // R8
   idle_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |-> (!integ_active && !oe_clk_en && !pix_stb));

   // R8
   lvl_low_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(run_en) |-> !oe_clk_lvl);

   // R9
   parallel_forces_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      par_style |-> !speed_hi);
endmodule

bind oe_timing_gen oe_timing_chk chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .run_en       (run_en),
   .par_style    (par_style),
   .oe_clk_en    (oe_clk_en),
   .oe_clk_lvl   (oe_clk_lvl),
   .pix_stb      (pix_stb),
   .integ_active (integ_active),
   .speed_hi     (speed_hi)
);

// File: tb/oe_timing_gen_tb.sv
module oe_timing_gen_tb_top;
   localparam int NV = 5;
   localparam int V_DIV [NV] = '{1, 3, 5, 2, 7};
   localparam int V_INT [NV] = '{1, 2, 0, 4, 3};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run_en = 1'b0;
   logic [8:0]  div_value = '0;
   logic        div_load = 1'b0;
   logic [31:0] int_time = 32'd1;
   logic        par_style = 1'b0;
   logic        hi_speed = 1'b0;
   logic        gain_in = 1'b0;
   logic        oe_clk_en, oe_clk_lvl, pix_stb, integ_active, speed_hi, gain_hi;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   oe_timing_gen dut_i (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .div_value(div_value),
      .div_load(div_load), .int_time(int_time), .par_style(par_style),
      .hi_speed(hi_speed), .gain_in(gain_in), .oe_clk_en(oe_clk_en),
      .oe_clk_lvl(oe_clk_lvl), .pix_stb(pix_stb), .integ_active(integ_active),
      .speed_hi(speed_hi), .gain_hi(gain_hi)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic stop_and_load(input int dv, input bit do_load);
      @(negedge clk);
      run_en = 1'b0;
      if (do_load) begin
         div_value = 9'(dv);
         div_load  = 1'b1;
      end
      @(negedge clk);
      div_load = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic first_tick(output int t_tick);
      t_tick = -1;
      run_en = 1'b1;
      for (int t = 0; t < 64; t++) begin
         #1;
         if (oe_clk_en && t_tick < 0) t_tick = t;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int tt;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      // R4: idle outputs after reset
      chk("R4 oe_clk_en", int'(oe_clk_en), 0);
      chk("R4 oe_clk_lvl", int'(oe_clk_lvl), 0);
      chk("R4 pix_stb", int'(pix_stb), 0);
      chk("R4 integ_active", int'(integ_active), 0);
      @(negedge clk);
      // R4: reset divider is 10
      first_tick(tt);
      chk("R4 default divider first tick", tt, 9);

      // Vector table walk: R1, R5, R6, R7
      for (int v = 0; v < NV; v++) begin
         int d, n, f_tick, f_rise, f_pix, a_end, re_open;
         d = V_DIV[v];
         n = (V_INT[v] == 0) ? 1 : V_INT[v];
         stop_and_load(d, 1'b1);
         int_time = 32'(V_INT[v]);
         run_en = 1'b1;
         f_tick = -1; f_rise = -1; f_pix = -1; a_end = -1; re_open = -1;
         for (int t = 0; t < 16 * d + 4; t++) begin
            #1;
            if (oe_clk_en && f_tick < 0) f_tick = t;
            if (oe_clk_lvl && f_rise < 0) f_rise = t;
            if (pix_stb && f_pix < 0) f_pix = t;
            if (!integ_active && a_end < 0) a_end = t;
            if (integ_active && a_end >= 0 && re_open < 0) re_open = t;
            @(negedge clk);
         end
         chk($sformatf("R1 first tick div=%0d", d), f_tick, d - 1);
         chk($sformatf("R1 first high div=%0d", d), f_rise, d);
         chk($sformatf("R5 first pixel strobe div=%0d", d), f_pix, 16 * d - 1);
         chk($sformatf("R6 window length div=%0d n=%0d", d, V_INT[v]), a_end, n * 2 * d);
         chk($sformatf("R7 gap length div=%0d", d), re_open - a_end, 2 * d);
      end

      // R2: zero load ignored
      stop_and_load(3, 1'b1);
      stop_and_load(0, 1'b1);
      first_tick(tt);
      chk("R2 zero divider ignored", tt, 2);

      // R3: divider change applied at period end only
      stop_and_load(4, 1'b1);
      run_en = 1'b1;
      for (int t = 0; t < 14; t++) begin
         #1;
         if (t == 7)  chk("R3 high half kept at t7", int'(oe_clk_lvl), 1);
         if (t == 8)  chk("R3 low after old period t8", int'(oe_clk_lvl), 0);
         if (t == 10) chk("R3 new half period high t10", int'(oe_clk_lvl), 1);
         if (t == 12) chk("R3 new half period low t12", int'(oe_clk_lvl), 0);
         if (t == 2) begin
            div_value = 9'd2;
            div_load  = 1'b1;
         end else begin
            div_load = 1'b0;
         end
         @(negedge clk);
      end

      // R8: stopping idles outputs
      stop_and_load(3, 1'b1);
      run_en = 1'b1;
      repeat (4) @(negedge clk);
      #1;
      chk("R8 window open before stop", int'(integ_active), 1);
      chk("R8 level high before stop", int'(oe_clk_lvl), 1);
      run_en = 1'b0;
      #1;
      chk("R8 window closes at once", int'(integ_active), 0);
      chk("R8 enable drops at once", int'(oe_clk_en), 0);
      @(negedge clk);
      #1;
      chk("R8 level low next cycle", int'(oe_clk_lvl), 0);

      // R9, R10: mode outputs
      hi_speed = 1'b1; par_style = 1'b0; gain_in = 1'b1;
      #1;
      chk("R9 high speed kept", int'(speed_hi), 1);
      chk("R10 gain high", int'(gain_hi), 1);
      par_style = 1'b1; gain_in = 1'b0;
      #1;
      chk("R9 parallel forces normal", int'(speed_hi), 0);
      chk("R10 gain low", int'(gain_hi), 0);
      hi_speed = 1'b0; par_style = 1'b0;
      #1;
      chk("R9 normal requested", int'(speed_hi), 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule